// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. A start pulse sets it off on a binary search over the output code. The search decides one bit per clock, from the most significant bit down. On every clock the current trial code drives an external DAC. A single comparator bit reports whether the analog input sits at or above the DAC level. The controller keeps or drops the bit under test on that result and then raises the next lower bit for testing.

Once the least significant bit is decided, the code output holds the converted value and end-of-conversion goes high. Both stay that way until the next start. The DAC and the comparator are outside the block. In the bench they are replaced by an ideal numeric comparison.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears `code` and `eoc` to 0 and leaves the controller idle, so that it waits for a start.
- R2: When `soc` is 1 at a clock edge while idle, that edge loads `code` with only its most significant bit set (8'h80 at width 8) and drives `eoc` low.
- R3: During a conversion, `cmp_hi` = 1 at an edge keeps the bit under test at 1 and sets the next lower bit (for example 8'h80 becomes 8'hC0).
- R4: During a conversion, `cmp_hi` = 0 at an edge clears the bit under test and sets the next lower bit (for example 8'hE0 becomes 8'hD0).
- R5: One bit is decided per clock, and `eoc` rises at exactly the 8th edge after the edge that accepted the start.
- R6: If the comparator reports 1 whenever the input is at or above the trial code, the final `code` equals the largest code not exceeding the input. With integer inputs this means `code` equals the input.
- R7: While `eoc` is high and `soc` is low, `eoc` stays high and `code` does not change.
- R8: A `soc` that is high during a conversion has no effect: the search goes on, with the same latency and the same result.
- R9: A `soc` that arrives while `eoc` is high starts a new conversion and drops `eoc` at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| soc | input | 1 | Start-of-conversion request |
| cmp_hi | input | 1 | Comparator result: 1 when the input is at or above the DAC level |
| code | output | WIDTH | Trial code to the DAC; the converted value once `eoc` is high |
| eoc | output | 1 | End of conversion; held until the next start |

## Verification
The bench builds the controller at its default width of 8. At that width every input value from 0 to 255 can be converted against an ideal comparator in a few thousand clocks. The sweep therefore covers the result and the latency for every keep/clear pattern the search can take, including the all-ones and all-zeros extremes. Around the sweep, the bench holds the start high through a whole conversion, restarts from a finished result, idles with a result held, and resets in the middle of a search.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soc,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] code,
  output logic             eoc
);
  localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] LSB = {{(WIDTH-1){1'b0}}, 1'b1};

  // one-hot pointer to the bit under test; zero when idle
  logic [WIDTH-1:0] probe;
  logic             busy;

  assign busy = |probe;

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      probe <= '0;
      eoc   <= 1'b0;
    end else if (!busy) begin
      if (soc) begin
        code  <= TOP;
        probe <= TOP;
        eoc   <= 1'b0;
      end
    end else begin
      code  <= (cmp_hi ? code : (code & ~probe)) | (probe >> 1);
      probe <= probe >> 1;
      if (probe[0]) eoc <= 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (code == '0 && !eoc && !busy));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && soc) |=> (code == TOP && !eoc));

  assert_decision_R3_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (((code & $past(probe)) != '0) == $past(cmp_hi)));

  assert_one_bit_per_clock_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc) |-> ($past(probe) == LSB));

  assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
    (eoc && !soc) |=> (eoc && $stable(code)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (probe == ($past(probe) >> 1)));

  assert_pointer_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(probe));
endmodule

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soc = 1'b0;
  logic [7:0] vin = 8'd0;
  logic       cmp_hi;
  logic [7:0] code;
  logic       eoc;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  // reference model state
  int m_code = 0;
  int m_k    = -1;
  bit m_eoc  = 0;

  always #10 clk = ~clk;

  assign cmp_hi = (vin >= code);

  sar_ctrl #(.WIDTH(8)) u0 (
    .clk(clk), .rst(rst), .soc(soc), .cmp_hi(cmp_hi), .code(code), .eoc(eoc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_next();
    if (rst) begin
      m_code = 0; m_k = -1; m_eoc = 0;
    end else if (m_k < 0) begin
      if (soc) begin
        m_code = 128; m_k = 7; m_eoc = 0;
      end
    end else begin
      if (!(vin >= m_code)) m_code = m_code & ~(1 << m_k);
      if (m_k > 0) m_code = m_code | (1 << (m_k - 1));
      else m_eoc = 1;
      m_k = m_k - 1;
    end
  endtask

  // one clock: model update, edge, compare at the falling edge
  task automatic step();
    string tag;
    tag = (m_k < 0) ? (soc ? "R2" : "R7") : ((vin >= m_code) ? "R3" : "R4");
    model_next();
    @(posedge clk);
    @(negedge clk);
    check(code == m_code[7:0], {tag, " code per clock"}, code, m_code);
    check(eoc == m_eoc, {tag, " eoc per clock"}, eoc, m_eoc);
  endtask

  task automatic convert(input logic [7:0] v, input bit hold_start, output int lat);
    vin = v;
    soc = 1'b1;
    step();
    if (!hold_start) soc = 1'b0;
    lat = 0;
    while (!eoc && lat < 20) begin
      step();
      lat++;
    end
    soc = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    // R1: reset state
    check(code == 8'd0, "R1 code after reset", code, 0);
    check(eoc == 1'b0, "R1 eoc after reset", eoc, 0);

    // R2: first trial code
    vin = 8'hD0;
    soc = 1'b1;
    step();
    soc = 1'b0;
    check(code == 8'h80, "R2 first trial", code, 8'h80);
    check(eoc == 1'b0, "R2 eoc low", eoc, 0);
    step();
    check(code == 8'hC0, "R3 keep and set next", code, 8'hC0);
    step();
    check(code == 8'hE0, "R3 keep and set next", code, 8'hE0);
    step();
    check(code == 8'hD0, "R4 clear and set next", code, 8'hD0);
    for (int i = 0; i < 5; i++) step();
    check(eoc == 1'b1, "R5 eoc after 8 decisions", eoc, 1);
    check(code == 8'hD0, "R6 result for D0", code, 8'hD0);

    // R6/R5: full sweep
    for (int v = 0; v < 256; v++) begin
      convert(v[7:0], 1'b0, lat);
      check(lat == 8, "R5 latency", lat, 8);
      check(code == v[7:0], "R6 sweep result", code, v);
    end

    // R7: result held while idle
    for (int i = 0; i < 5; i++) step();
    check(eoc == 1'b1, "R7 eoc held", eoc, 1);
    check(code == 8'hFF, "R7 code held", code, 8'hFF);

    // R9: restart from done
    vin = 8'h21;
    soc = 1'b1;
    step();
    soc = 1'b0;
    check(eoc == 1'b0, "R9 eoc dropped on restart", eoc, 0);
    check(code == 8'h80, "R9 restart trial", code, 8'h80);
    lat = 0;
    while (!eoc && lat < 20) begin step(); lat++; end
    check(code == 8'h21, "R9 restart result", code, 8'h21);

    // R8: start held high through a conversion
    convert(8'h5A, 1'b1, lat);
    check(lat == 8, "R8 latency with start held", lat, 8);
    check(code == 8'h5A, "R8 result with start held", code, 8'h5A);

    // R1: reset in the middle of a search
    vin = 8'h77;
    soc = 1'b1;
    step();
    soc = 1'b0;
    step();
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check(code == 8'd0, "R1 mid-search reset code", code, 0);
    check(eoc == 1'b0, "R1 mid-search reset eoc", eoc, 0);
    for (int i = 0; i < 10; i++) step();
    check(eoc == 1'b0, "R1 idle after reset", eoc, 0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule